// File: doc/BRIEF.md
# 64-bit Global Timer with Comparator

The block is a free-running 64-bit up-counter with a 64-bit compare register. Software reaches it through a small 32-bit register port: byte address, write strobe, write data and a combinational read-data return. The counter advances once every (prescale + 1) clock cycles while it is enabled. When the comparator is enabled and the counter has reached or passed the compare value, an event flag is raised. The flag drives one interrupt line through an enable bit, and software clears it by writing a one to it.

In periodic mode, each consumed match adds a programmable 32-bit step to the compare value. The block then produces a steady train of events with no software reload. In one-shot mode, a single crossing raises the flag once. Writing either half of the compare register arms detection again.

Top module: `glob_timer`

## Requirements
- R1: After synchronous reset, every register reads as zero, the counter does not advance and `irq` is low.
- R2: The counter low word (offset 0x00) and high word (offset 0x04) can each be written and read back exactly while counting is disabled, and the counter holds its value while disabled.
- R3: With counting enabled (control bit 0) and prescale 0, the counter increases by one per clock, and a carry out of the low word increments the high word.
- R4: With prescale value P in control bits 15:8, the counter advances once every P+1 clocks, measured from the enabling write.
- R5: The control word (offset 0x08) reads back bits 0..3 and 15:8 as written, and all other bits read as zero.
- R6: With comparator enable (control bit 1) set, status bit 0 (offset 0x0C) becomes 1 when the counter is greater than or equal to the 64-bit compare value (offsets 0x10 low, 0x14 high), and stays 0 while the counter is below it.
- R7: `irq` is high exactly while status bit 0 is set and interrupt enable (control bit 2) is 1.
- R8: Writing 1 to status bit 0 clears the flag. Writing 0 leaves it unchanged.
- R9: Without auto-increment, a standing match raises the flag only once. A write to either compare half arms detection again.
- R10: The flag is never set while the comparator is disabled. Clearing the comparator enable does not clear a flag that is already set.
- R11: With auto-increment (control bit 3) set, each consumed match adds the 32-bit step (offset 0x18, read back as written) to the compare value and sets the flag.
- R12: Addresses outside the seven word offsets, including misaligned ones, read as zero and ignore writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 5 | Byte address of the register access |
| we | input | 1 | Write strobe, sampled on the rising edge |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| irq | output | 1 | Interrupt request |

## Verification
The bench uses the package defaults: a 32-bit data word, an 8-bit prescaler and a 64-bit counter. Because the counter halves can be preloaded, a carry across the low word is reached in a few cycles. The small prescale value of 2 makes the P+1 spacing countable within ten clocks. A step of 10 lets the periodic reload fire four times inside a 45-cycle run, and the final counter and compare values are predicted edge by edge.

// File: rtl/gtmr_pkg.sv
package gtmr_pkg;

    localparam int DW     = 32;
    localparam int CW     = 2 * DW;
    localparam int PSC_W  = 8;
    localparam int PSC_LSB = 8;
    localparam int AW     = 5;

    localparam logic [AW-1:0] OFS_CNT_LO = 5'h00;
    localparam logic [AW-1:0] OFS_CNT_HI = 5'h04;
    localparam logic [AW-1:0] OFS_CTRL   = 5'h08;
    localparam logic [AW-1:0] OFS_STAT   = 5'h0C;
    localparam logic [AW-1:0] OFS_CMP_LO = 5'h10;
    localparam logic [AW-1:0] OFS_CMP_HI = 5'h14;
    localparam logic [AW-1:0] OFS_STEP   = 5'h18;

    typedef struct packed {
        logic [PSC_W-1:0] psc;
        logic             auto_inc;
        logic             irq_en;
        logic             cmp_en;
        logic             run;
    } ctrl_t;

    typedef enum logic [2:0] {
        SEL_NONE, SEL_CNT_LO, SEL_CNT_HI, SEL_CTRL,
        SEL_STAT, SEL_CMP_LO, SEL_CMP_HI, SEL_STEP
    } sel_e;

    function automatic ctrl_t unpack_ctrl(input logic [DW-1:0] w);
        ctrl_t c;
        c.run      = w[0];
        c.cmp_en   = w[1];
        c.irq_en   = w[2];
        c.auto_inc = w[3];
        c.psc      = w[PSC_LSB +: PSC_W];
        return c;
    endfunction

    function automatic logic [DW-1:0] pack_ctrl(input ctrl_t c);
        logic [DW-1:0] w;
        w = '0;
        w[0] = c.run;
        w[1] = c.cmp_en;
        w[2] = c.irq_en;
        w[3] = c.auto_inc;
        w[PSC_LSB +: PSC_W] = c.psc;
        return w;
    endfunction

    function automatic sel_e decode(input logic [AW-1:0] a);
        case (a)
            OFS_CNT_LO: return SEL_CNT_LO;
            OFS_CNT_HI: return SEL_CNT_HI;
            OFS_CTRL:   return SEL_CTRL;
            OFS_STAT:   return SEL_STAT;
            OFS_CMP_LO: return SEL_CMP_LO;
            OFS_CMP_HI: return SEL_CMP_HI;
            OFS_STEP:   return SEL_STEP;
            default:    return SEL_NONE;
        endcase
    endfunction

endpackage

// File: rtl/gtmr_presc.sv
module gtmr_presc #(
    parameter int PSC_W = gtmr_pkg::PSC_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [PSC_W-1:0] psc,
    output logic             tick
);
    logic [PSC_W-1:0] div_q;

    assign tick = run && (div_q >= psc);

    always_ff @(posedge clk) begin
        if (rst || !run)
            div_q <= '0;
        else if (tick)
            div_q <= '0;
        else
            div_q <= div_q + PSC_W'(1);
    end

    // R4: a nonzero prescale never yields ticks on back-to-back cycles
    a_r4_tick_gap: assert property (@(posedge clk) disable iff (rst)
        (tick && psc != '0) |=> (!tick || psc != $past(psc)));

endmodule

// File: rtl/gtmr_count.sv
module gtmr_count #(
    parameter int DW = gtmr_pkg::DW,
    parameter int CW = 2 * DW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  logic          wr_lo,
    input  logic          wr_hi,
    input  logic [DW-1:0] wdata,
    output logic [CW-1:0] cnt
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else begin
            if (tick)
                cnt <= cnt + CW'(1);
            if (wr_lo)
                cnt[DW-1:0] <= wdata;
            if (wr_hi)
                cnt[CW-1:DW] <= wdata;
        end
    end

    // R3: one step per tick, carry included
    a_r3_count_step: assert property (@(posedge clk) disable iff (rst)
        (tick && !wr_lo && !wr_hi) |=> cnt == $past(cnt) + CW'(1));

    // R2: no tick and no write leaves the counter alone
    a_r2_hold_idle: assert property (@(posedge clk) disable iff (rst)
        (!tick && !wr_lo && !wr_hi) |=> $stable(cnt));

endmodule

// File: rtl/gtmr_cmp.sv
module gtmr_cmp #(
    parameter int DW = gtmr_pkg::DW,
    parameter int CW = 2 * DW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [CW-1:0] cnt,
    input  logic          cmp_en,
    input  logic          auto_inc,
    input  logic          wr_lo,
    input  logic          wr_hi,
    input  logic          wr_step,
    input  logic          clr_flag,
    input  logic [DW-1:0] wdata,
    output logic [CW-1:0] cmp,
    output logic [DW-1:0] step,
    output logic          flag
);
    logic hit, hit_q, fire;

    assign hit  = cmp_en && (cnt >= cmp);
    assign fire = hit && (auto_inc || !hit_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            cmp   <= '0;
            step  <= '0;
            flag  <= 1'b0;
            hit_q <= 1'b0;
        end else begin
            hit_q <= (wr_lo || wr_hi) ? 1'b0 : hit;
            if (fire && auto_inc)
                cmp <= cmp + {{(CW-DW){1'b0}}, step};
            if (wr_lo)
                cmp[DW-1:0] <= wdata;
            if (wr_hi)
                cmp[CW-1:DW] <= wdata;
            if (wr_step)
                step <= wdata;
            if (fire)
                flag <= 1'b1;
            else if (clr_flag)
                flag <= 1'b0;
        end
    end

    // R10: an existing flag only leaves through a clear
    a_r10_flag_sticky: assert property (@(posedge clk) disable iff (rst)
        (flag && !clr_flag) |=> flag);

    // R10: a disabled comparator never raises the flag
    a_r10_no_set_disabled: assert property (@(posedge clk) disable iff (rst)
        (!cmp_en && !flag) |=> !flag);

    // R8: a clear with the comparator off always takes effect
    a_r8_clear_takes: assert property (@(posedge clk) disable iff (rst)
        (clr_flag && !cmp_en) |=> !flag);

    // R11: a consumed periodic match moves the compare value by the step
    a_r11_reload_step: assert property (@(posedge clk) disable iff (rst)
        (fire && auto_inc && !wr_lo && !wr_hi)
        |=> cmp == $past(cmp) + {{(CW-DW){1'b0}}, $past(step)});

endmodule

// File: rtl/glob_timer.sv
module glob_timer
    import gtmr_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] addr,
    input  logic          we,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    output logic          irq
);
    sel_e          sel;
    ctrl_t         ctrl_q;
    logic          tick;
    logic [CW-1:0] cnt;
    logic [CW-1:0] cmp;
    logic [DW-1:0] step;
    logic          flag;

    assign sel = decode(addr);

    always_ff @(posedge clk) begin
        if (rst)
            ctrl_q <= '0;
        else if (we && sel == SEL_CTRL)
            ctrl_q <= unpack_ctrl(wdata);
    end

    gtmr_presc #(.PSC_W(PSC_W)) u_presc (
        .clk  (clk),
        .rst  (rst),
        .run  (ctrl_q.run),
        .psc  (ctrl_q.psc),
        .tick (tick)
    );

    gtmr_count #(.DW(DW), .CW(CW)) u_count (
        .clk   (clk),
        .rst   (rst),
        .tick  (tick),
        .wr_lo (we && sel == SEL_CNT_LO),
        .wr_hi (we && sel == SEL_CNT_HI),
        .wdata (wdata),
        .cnt   (cnt)
    );

    gtmr_cmp #(.DW(DW), .CW(CW)) u_cmp (
        .clk      (clk),
        .rst      (rst),
        .cnt      (cnt),
        .cmp_en   (ctrl_q.cmp_en),
        .auto_inc (ctrl_q.auto_inc),
        .wr_lo    (we && sel == SEL_CMP_LO),
        .wr_hi    (we && sel == SEL_CMP_HI),
        .wr_step  (we && sel == SEL_STEP),
        .clr_flag (we && sel == SEL_STAT && wdata[0]),
        .wdata    (wdata),
        .cmp      (cmp),
        .step     (step),
        .flag     (flag)
    );

    assign irq = flag && ctrl_q.irq_en;

    always_comb begin
        case (sel)
            SEL_CNT_LO: rdata = cnt[DW-1:0];
            SEL_CNT_HI: rdata = cnt[CW-1:DW];
            SEL_CTRL:   rdata = pack_ctrl(ctrl_q);
            SEL_STAT:   rdata = {{(DW-1){1'b0}}, flag};
            SEL_CMP_LO: rdata = cmp[DW-1:0];
            SEL_CMP_HI: rdata = cmp[CW-1:DW];
            SEL_STEP:   rdata = step;
            default:    rdata = '0;
        endcase
    end

    // R7: the interrupt line never rises without an event pending
    a_r7_irq_needs_flag: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> flag);

endmodule

// File: tb/sim_glob_timer.sv
module sim_glob_timer;
    timeunit 1ns;
    timeprecision 1ps;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [4:0]  addr = '0;
    logic        we = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    logic [31:0] exp_q[$];
    string       tag_q[$];
    bit          irq_q[$];
    event        chk_ev;

    always #5 clk = ~clk;

    glob_timer u0 (
        .clk(clk), .rst(rst), .addr(addr), .we(we),
        .wdata(wdata), .rdata(rdata), .irq(irq)
    );

    // all driver tasks start and end on a falling edge
    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        addr = a; wdata = d; we = 1'b1;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_rd(input logic [4:0] a, input logic [31:0] e, input string t);
        addr = a;
        exp_q.push_back(e); tag_q.push_back(t); irq_q.push_back(1'b0);
        -> chk_ev;
        @(negedge clk);
    endtask

    task automatic expect_irq(input logic e, input string t);
        exp_q.push_back({31'b0, e}); tag_q.push_back(t); irq_q.push_back(1'b1);
        -> chk_ev;
        @(negedge clk);
    endtask

    // monitor: pops each expected item and compares with the port
    initial begin
        forever begin
            @(chk_ev);
            #1;
            begin
                logic [31:0] e;
                logic [31:0] got;
                string t;
                bit is_irq;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                is_irq = irq_q.pop_front();
                got = is_irq ? {31'b0, irq} : rdata;
                checks++;
                if (got !== e) begin
                    failures++;
                    $display("FAIL %s: got %h expected %h", t, got, e);
                end
            end
        end
    end

    initial begin
        #2000000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        idle(3);
        rst = 1'b0;
        idle(1);

        // R1 reset state
        expect_rd(5'h08, 32'h0, "R1 ctrl");
        expect_rd(5'h00, 32'h0, "R1 cnt lo");
        idle(2);
        expect_rd(5'h00, 32'h0, "R1 counter stopped");
        expect_rd(5'h0C, 32'h0, "R1 status");
        expect_irq(1'b0, "R1 irq");

        // R2 load halves while stopped
        wr(5'h00, 32'hFFFF_FFFE);
        wr(5'h04, 32'h0000_0005);
        idle(3);
        expect_rd(5'h00, 32'hFFFF_FFFE, "R2 lo");
        expect_rd(5'h04, 32'h0000_0005, "R2 hi");

        // R3 four counting edges, carry into high word
        wr(5'h08, 32'h1);
        idle(3);
        wr(5'h08, 32'h0);
        expect_rd(5'h04, 32'h6, "R3 hi carry");
        expect_rd(5'h00, 32'h2, "R3 lo");

        // R4 prescale 2, ten edges -> three steps
        wr(5'h00, 32'h0);
        wr(5'h04, 32'h0);
        wr(5'h08, 32'h0201);
        idle(9);
        wr(5'h08, 32'h0200);
        expect_rd(5'h00, 32'h3, "R4 prescaled count");

        // R5 control readback masks unused bits
        expect_rd(5'h08, 32'h0200, "R5 ctrl psc");
        wr(5'h08, 32'hFFFF_FFF0);
        expect_rd(5'h08, 32'h0000_FF00, "R5 ctrl mask");
        wr(5'h08, 32'h0);

        // R6 below then at/above compare
        wr(5'h00, 32'd100);
        wr(5'h10, 32'd200);
        wr(5'h14, 32'd0);
        wr(5'h08, 32'h2);
        idle(2);
        expect_rd(5'h0C, 32'h0, "R6 below compare");
        wr(5'h10, 32'd50);
        idle(2);
        expect_rd(5'h0C, 32'h1, "R6 greater-or-equal");
        expect_irq(1'b0, "R7 irq gated off");
        wr(5'h08, 32'h6);
        idle(1);
        expect_irq(1'b1, "R7 irq on");

        // R8 write-one-to-clear
        wr(5'h0C, 32'h0);
        idle(2);
        expect_rd(5'h0C, 32'h1, "R8 zero write ignored");
        wr(5'h0C, 32'h1);
        idle(2);
        expect_rd(5'h0C, 32'h0, "R9 standing match no refire");
        expect_irq(1'b0, "R7 irq after clear");

        // R9 compare write rearms
        wr(5'h10, 32'd60);
        idle(2);
        expect_rd(5'h0C, 32'h1, "R9 rearm");

        // R10 disable keeps flag, disabled never sets
        wr(5'h08, 32'h0);
        idle(2);
        expect_rd(5'h0C, 32'h1, "R10 sticky");
        wr(5'h0C, 32'h1);
        wr(5'h10, 32'd40);
        idle(2);
        expect_rd(5'h0C, 32'h0, "R10 disabled no set");

        // R11 single consumed match with counter stopped
        wr(5'h10, 32'd100);
        wr(5'h18, 32'd30);
        wr(5'h08, 32'hA);
        idle(2);
        expect_rd(5'h10, 32'd130, "R11 reload");
        expect_rd(5'h0C, 32'h1, "R11 flag");
        expect_rd(5'h18, 32'd30, "R11 step readback");
        wr(5'h08, 32'h0);
        wr(5'h0C, 32'h1);

        // R11 periodic: 45 running edges, step 10, first compare 10
        wr(5'h00, 32'h0);
        wr(5'h10, 32'd10);
        wr(5'h18, 32'd10);
        wr(5'h08, 32'hB);
        idle(44);
        wr(5'h08, 32'h0);
        expect_rd(5'h10, 32'd50, "R11 periodic compare");
        expect_rd(5'h14, 32'd0, "R11 periodic compare hi");
        expect_rd(5'h00, 32'd45, "R11 periodic count");
        expect_rd(5'h0C, 32'h1, "R11 periodic flag");

        // R12 unmapped addresses
        wr(5'h1C, 32'hFFFF_FFFF);
        expect_rd(5'h1C, 32'h0, "R12 unmapped read");
        expect_rd(5'h02, 32'h0, "R12 misaligned read");
        wr(5'h09, 32'h0000_0001);
        expect_rd(5'h08, 32'h0, "R12 write ignored");

        idle(2);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule